// File: doc/BRIEF.md
# Ripple Successive-Approximation Result Register

This block collects the comparator decisions of one successive-approximation conversion. It is built as a chain of identical slices. Each slice owns one bit of the result as a pair of complementary flags, one positive and one negative. A single arming token travels down the chain. A rising edge on the sample-end input clears every flag and arms the first slice. The armed slice holds the comparator clock request low, watches the comparator while the valid strobe is high, and commits its decision when valid falls. It then hands the token to the next slice.

After the last slice commits, the chain raises `done`. The converted code can then be read as the positive flags, most significant bit first. The comparator, its timing and the capacitor array are outside this block. The block only sees the comparator's two digital outputs and its valid strobe.

Top module: `sar_ripple_reg`

## Requirements
- R1: While `rst_n` is low, every `bit_p` and `bit_n` flag is 0, `done` is 0 and `cmp_clk_n` is 1.
- R2: The clock edge that first samples `conv_start` high after it was sampled low clears all flags and `done`, and arms the first slice. `cmp_clk_n` is therefore low after that edge.
- R3: A slice's decision is positive when, in the last cycle `valid` was high, `cmp_p` was 1 and `cmp_n` was 0. Every other combination is a negative decision, including 1/1 and 0/0.
- R4: On the clock edge that first samples `valid` low after it was high, the armed slice writes its flags: `bit_p`=1 and `bit_n`=0 for a positive decision, and `bit_p`=0 and `bit_n`=1 for a negative one. Slice k drives bit index NBITS-1-k, so results fill from the MSB (index NBITS-1) down to index 0, one per valid strobe.
- R5: A bit index never has both `bit_p` and `bit_n` set. A slice that has not committed shows 0 on both.
- R6: A committed flag pair stays unchanged until the next sample-end edge.
- R7: `done` rises on the edge one cycle after the edge that commits the last slice, and stays high until the next sample-end edge. `cmp_clk_n` is high from the last commit onward.
- R8: A falling `valid` while no slice is armed changes no flag and no output. This covers the time before the first sample-end edge and the time after `done`.
- R9: At most one slice is armed at a time, and `cmp_clk_n` is low exactly while some slice is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Sample-end signal; its rising edge starts a conversion |
| cmp_p | input | 1 | Comparator positive output |
| cmp_n | input | 1 | Comparator negative output |
| valid | input | 1 | Comparator valid strobe; its falling edge commits a decision |
| bit_p | output | NBITS | Positive decision flags, index NBITS-1 is the MSB |
| bit_n | output | NBITS | Negative decision flags |
| cmp_clk_n | output | 1 | Comparator clock request, low while a slice is armed |
| done | output | 1 | Conversion complete |

## Verification
A token that is lost, duplicated or sent to the wrong slice shows up at the ports on the edge right after the valid strobe that misroutes it. The symptoms are a flag pair at the wrong bit index, two pairs written at once, or a `cmp_clk_n` level that no longer matches the count of remaining strobes. A wrong decision register shows up as a swapped P/N pair at the expected index on that same edge. A broken hold path shows up as flags that change on a stray strobe after `done`. A late or early completion shows up as `done` off by one cycle against the last commit.

// File: rtl/sar_ripple_reg.sv
module sar_ripple_reg #(
  parameter int NBITS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic             cmp_p,
  input  logic             cmp_n,
  input  logic             valid,
  output logic [NBITS-1:0] bit_p,
  output logic [NBITS-1:0] bit_n,
  output logic             cmp_clk_n,
  output logic             done
);

  logic             start_q, valid_q, dec_q;
  logic [NBITS-1:0] armed, fin, slice_p, slice_n;
  logic [NBITS-1:0] take, prev_take;
  logic             start_edge, strobe_fall;

  assign start_edge  = conv_start & ~start_q;
  assign strobe_fall = valid_q & ~valid;
  assign take        = armed & {NBITS{strobe_fall}};
  assign prev_take   = {take[NBITS-2:0], 1'b0};
  assign cmp_clk_n   = ~(|armed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      valid_q <= 1'b0;
      dec_q   <= 1'b0;
    end else begin
      start_q <= conv_start;
      valid_q <= valid;
      if (valid) dec_q <= cmp_p & ~cmp_n;
    end
  end

  for (genvar k = 0; k < NBITS; k++) begin : g_slice
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        armed[k]   <= 1'b0;
        fin[k]     <= 1'b0;
        slice_p[k] <= 1'b0;
        slice_n[k] <= 1'b0;
      end else if (start_edge) begin
        armed[k]   <= (k == 0);
        fin[k]     <= 1'b0;
        slice_p[k] <= 1'b0;
        slice_n[k] <= 1'b0;
      end else if (take[k]) begin
        armed[k]   <= 1'b0;
        fin[k]     <= 1'b1;
        slice_p[k] <= dec_q;
        slice_n[k] <= ~dec_q;
      end else if (prev_take[k]) begin
        armed[k]   <= 1'b1;
      end
    end
    assign bit_p[NBITS-1-k] = slice_p[k];
    assign bit_n[NBITS-1-k] = slice_n[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          done <= 1'b0;
    else if (start_edge) done <= 1'b0;
    else                 done <= fin[NBITS-1];
  end

endmodule

// File: rtl/sar_ripple_chk.sv
module sar_ripple_chk #(
  parameter int NBITS = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_edge,
  input logic [NBITS-1:0] armed,
  input logic [NBITS-1:0] fin,
  input logic [NBITS-1:0] bit_p,
  input logic [NBITS-1:0] bit_n,
  input logic             cmp_clk_n,
  input logic             done
);

  // R9
  single_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(armed));

  // R9
  clk_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_clk_n == ($countones(armed) == 0));

  // R5
  exclusive_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_p & bit_n) == '0);

  // R6
  hold_p_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_edge |=> ((bit_p & $past(bit_p)) == $past(bit_p)));

  // R6
  hold_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_edge |=> ((bit_n & $past(bit_n)) == $past(bit_n)));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmp_clk_n);

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(fin[NBITS-1]));

  // R2
  start_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_edge |=> (!cmp_clk_n && bit_p == '0 && bit_n == '0 && !done));

endmodule

bind sar_ripple_reg sar_ripple_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_edge(start_edge), .armed(armed), .fin(fin),
  .bit_p(bit_p), .bit_n(bit_n), .cmp_clk_n(cmp_clk_n), .done(done)
);

// File: tb/sim_sar_ripple_reg.sv
module sim_sar_ripple_reg;
  localparam int NB = 10;

  logic clk = 1'b0, rst_n = 1'b0, conv_start = 1'b0;
  logic cmp_p = 1'b0, cmp_n = 1'b0, valid = 1'b0;
  logic [NB-1:0] bit_p, bit_n;
  logic cmp_clk_n, done;
  int n_chk = 0, n_bad = 0;
  logic [NB-1:0] exp_p, exp_n;

  always #2 clk = ~clk;

  sar_ripple_reg #(.NBITS(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .cmp_p(cmp_p),
    .cmp_n(cmp_n), .valid(valid), .bit_p(bit_p), .bit_n(bit_n),
    .cmp_clk_n(cmp_clk_n), .done(done));

  function automatic logic decide(logic p, logic n);
    return p & ~n;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic flags_chk(string req);
    chk(req, 32'(bit_p), 32'(exp_p));
    chk(req, 32'(bit_n), 32'(exp_n));
  endtask

  task automatic start_conv();
    @(negedge clk) conv_start = 1'b1;
    @(negedge clk) conv_start = 1'b0;
    exp_p = '0; exp_n = '0;
    flags_chk("R2");
    chk("R2", 32'(done), 0);
    chk("R2", 32'(cmp_clk_n), 0);
  endtask

  task automatic do_bit(int k, logic p, logic n);
    logic d;
    chk("R9", 32'(cmp_clk_n), 0);
    valid = 1'b1; cmp_p = 1'($urandom); cmp_n = 1'($urandom);
    @(negedge clk) cmp_p = p; cmp_n = n;
    @(negedge clk) valid = 1'b0; cmp_p = 1'($urandom); cmp_n = 1'($urandom);
    @(negedge clk);
    d = decide(p, n);
    exp_p[NB-1-k] = d;
    exp_n[NB-1-k] = ~d;
    flags_chk("R3 R4");
    chk("R5", 32'(bit_p & bit_n), 0);
  endtask

  task automatic stray_strobe(string req);
    @(negedge clk) valid = 1'b1; cmp_p = 1'b1; cmp_n = 1'b0;
    @(negedge clk) valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    flags_chk(req);
    chk(req, 32'(cmp_clk_n), 1);
  endtask

  task automatic full_conv(logic [NB-1:0] pp, logic [NB-1:0] nn);
    start_conv();
    for (int k = 0; k < NB; k++) begin
      do_bit(k, pp[NB-1-k], nn[NB-1-k]);
      if (k == NB-1) begin
        chk("R7", 32'(done), 0);
        chk("R7", 32'(cmp_clk_n), 1);
        @(negedge clk);
        chk("R7", 32'(done), 1);
      end
    end
    flags_chk("R6");
  endtask

  initial begin
    void'($urandom(32'd7));
    exp_p = '0; exp_n = '0;
    repeat (3) @(negedge clk);
    flags_chk("R1");
    chk("R1", 32'(done), 0);
    chk("R1", 32'(cmp_clk_n), 1);
    rst_n = 1'b1;
    stray_strobe("R8");
    full_conv({NB{1'b1}}, {NB{1'b0}});
    full_conv({NB{1'b0}}, {NB{1'b1}});
    full_conv({NB{1'b1}}, {NB{1'b1}});
    full_conv({NB{1'b0}}, {NB{1'b0}});
    stray_strobe("R8");
    chk("R7", 32'(done), 1);
    start_conv();
    for (int k = 0; k < 3; k++) do_bit(k, 1'b1, 1'b0);
    start_conv();
    chk("R2", 32'(bit_p), 0);
    for (int t = 0; t < 20; t++)
      full_conv(NB'($urandom), NB'($urandom));
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    report();
  end
endmodule